// File: doc/BRIEF.md
# SPI-Mode Memory Card Protocol Engine

This block is the byte-level protocol engine behind a memory card that talks to its host over SPI. It sits after an SPI bit shifter: for every byte the shifter exchanges, the engine takes the byte that arrived from the host and, in the same slot, supplies the byte to send back. It parses six-byte command frames, plays out the card's response, streams 512-byte read blocks framed by a start token and a CRC16, and accepts write blocks, ending them with a data-response byte.

Storage sits behind three simple back-end ports. The command port gets an index and argument and returns, within the same slot, a response of one to five bytes. The read port offers one byte at a time with "available" and "last" flags. The write port takes one byte at a time and flags when it can take no more. Card initialisation, command CRC7 checking, write CRC16 checking and the memory itself are outside the block.

A slot is one clock cycle with `xferEn` high and `csN` low. Raising `csN` freezes the engine without resetting it.

Top module: `sdspi_engine`

## Requirements
- R1: After reset the engine is in command state, all counters and flags are clear, and every reply is 0xFF until a command arrives.
- R2: In command state an incoming 0xFF is an idle byte: the reply is 0xFF and the state does not change.
- R3: In command state any byte other than 0xFF, 0xFE, 0xFC and 0xFD starts a frame. Its low six bits are the command index. The next four bytes are the argument, most significant first. The sixth byte is the frame's CRC, which is not checked; during that slot `cmdValid` is high with `cmdIdx` and `cmdArg` presented. Every reply during the frame is 0xFF.
- R4: After a command is issued, one filler slot replies 0xFF. The next `cmdRespLen` slots (1 to 5) return the response bytes, byte i taken from `cmdResp[8*i+7:8*i]`.
- R5: For command indices 28, 29 and 38, one extra 0xFF follows the response, and the engine then returns to command state even if read data is available.
- R6: Once the response is complete, if `rdAvail` is high, the engine replies 0xFF, then the start token 0xFE, then one back-end byte per slot, pulsing `rdTake`. The block ends after 512 bytes or after a byte taken while `rdLast` is high.
- R7: Each read block is followed by two CRC bytes, high byte first. The CRC is CRC16 with polynomial 0x1021, processed MSB first and starting from zero for each block, taken over that block's data bytes.
- R8: After a full 512-byte read block, unless the command index was 17, the engine sends one 0xFF gap, then 0xFE, then the next block. Otherwise it returns to command state.
- R9: In any of the four read-phase states (gap, start token, data, CRC), an incoming 0x4C abandons the read. It starts a new frame with index 12, and it sets the stop flag, so one extra 0xFF follows that command's response.
- R10: In command state, 0xFE or 0xFC starts a write block. Each following byte is echoed and passed to the back end with `wrValid`. After 512 bytes, or after a byte accepted while `wrFull` is high, two CRC bytes are taken and answered with 0xFF. The next reply is then 0x05, followed by 0xFF and a return to command state.
- R11: In command state, 0xFD issues command index 12 with argument 0 on the command port. The next reply is 0x00 if the back end returned length 0 (busy) and 0xFF otherwise, followed by one extra 0xFF before command state.
- R12: Slots with `csN` high have no effect: the reply is 0xFF, no back-end strobe is raised and the state is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| xferEn | input | 1 | One byte exchanged in this cycle |
| rxByte | input | 8 | Byte received from the host |
| txByte | output | 8 | Reply byte for this slot (0xFF outside a slot) |
| cmdValid | output | 1 | Command issued to the back end this slot |
| cmdIdx | output | 6 | Command index |
| cmdArg | output | 32 | Command argument |
| cmdRespLen | input | 3 | Response length returned by the back end |
| cmdResp | input | 40 | Response bytes, byte 0 in the low bits |
| rdAvail | input | 1 | Back end has read data |
| rdLast | input | 1 | Offered read byte is the last one |
| rdByte | input | 8 | Offered read byte |
| rdTake | output | 1 | Read byte consumed this slot |
| wrValid | output | 1 | Write byte delivered this slot |
| wrByte | output | 8 | Write byte |
| wrFull | input | 1 | Back end can take no byte after this one |

## Verification
A wrong state in this engine shows up on `txByte` in the very slot it matters. A missed filler or gap slot shifts every later byte by one. A stale CRC register corrupts the two bytes that follow each block. A forgotten stop flag drops the extra 0xFF and lets the next frame start one slot early. A misplaced block counter ends a block on the wrong byte, which the back-end strobes reveal in that same slot. The reply byte and all back-end strobes are therefore compared against an independent slot-by-slot model on every exchange, so any divergence is caught in the first slot where it becomes visible.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

  typedef enum logic [3:0] {
    M_CMD, M_ARG, M_RGAP, M_RESP, M_DGAP,
    M_DSTART, M_DREAD, M_DCRC, M_DWRITE, M_WSKIP
  } mode_t;

  typedef enum logic [2:0] {
    O_IDLE, O_TOKEN, O_RESP, O_RDATA, O_CRC, O_ECHO
  } outSel_t;

  typedef struct packed {
    logic    newCmd;
    logic    argShift;
    logic    issueCmd;
    logic    issueStop;
    logic    respAdv;
    logic    posClr;
    logic    stopSet;
    logic    stopClr;
    logic    blockClr;
    logic    rdStep;
    logic    crcShift;
    logic    wrStep;
    logic    loadAccept;
    outSel_t outSel;
  } strobe_t;

  localparam logic [7:0] BYTE_IDLE    = 8'hFF;
  localparam logic [7:0] TOK_BLOCK    = 8'hFE;
  localparam logic [7:0] TOK_MULTI_WR = 8'hFC;
  localparam logic [7:0] TOK_STOP_WR  = 8'hFD;
  localparam logic [7:0] STOP_LEAD    = 8'h4C;
  localparam logic [7:0] WR_ACCEPTED  = 8'h05;
  localparam logic [5:0] IDX_STOP     = 6'd12;
  localparam logic [5:0] IDX_RD_ONE   = 6'd17;
  localparam logic [15:0] CRC_POLY    = 16'h1021;

  function automatic logic isBusyCmd(input logic [5:0] idx);
    return (idx == 6'd28) || (idx == 6'd29) || (idx == 6'd38);
  endfunction

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/sdspi_ctrl.sv
module sdspi_ctrl
  import sdspi_pkg::*;
#(
  parameter int BLOCK_BYTES = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       xferEn,
  input  logic [7:0] rxByte,
  input  logic       argFull,
  input  logic       respDone,
  input  logic       stopping,
  input  logic       blkLast,
  input  logic       blkFull,
  input  logic       seqLast,
  input  logic       singleRead,
  input  logic       rdAvail,
  input  logic       rdLast,
  input  logic       wrFull,
  output strobe_t    st
);

  mode_t mode, modeNxt, effMode;
  logic  slot, readPhase, abortRd;

  assign slot      = xferEn & ~csN;
  assign readPhase = (mode == M_DGAP) || (mode == M_DSTART) ||
                     (mode == M_DREAD) || (mode == M_DCRC);
  assign abortRd   = slot & readPhase & (rxByte == STOP_LEAD);
  assign effMode   = abortRd ? M_CMD : mode;

  always_comb begin
    st        = '0;
    st.outSel = O_IDLE;
    modeNxt   = mode;
    if (slot) begin
      st.stopSet = abortRd;
      unique case (effMode)
        M_CMD: begin
          if (rxByte == BYTE_IDLE) begin
            modeNxt = M_CMD;
          end else if (rxByte == TOK_BLOCK || rxByte == TOK_MULTI_WR) begin
            st.blockClr = 1'b1;
            modeNxt     = M_DWRITE;
          end else if (rxByte == TOK_STOP_WR) begin
            st.issueStop = 1'b1;
            modeNxt      = M_RESP;
          end else begin
            st.newCmd = 1'b1;
            modeNxt   = M_ARG;
          end
        end
        M_ARG: begin
          if (argFull) begin
            st.issueCmd = 1'b1;
            modeNxt     = M_RGAP;
          end else begin
            st.argShift = 1'b1;
          end
        end
        M_RGAP: modeNxt = M_RESP;
        M_RESP: begin
          if (!respDone) begin
            st.outSel  = O_RESP;
            st.respAdv = 1'b1;
          end else if (stopping) begin
            st.stopClr = 1'b1;
            modeNxt    = M_CMD;
          end else if (rdAvail) begin
            modeNxt = M_DSTART;
          end else begin
            modeNxt = M_CMD;
          end
        end
        M_DGAP: modeNxt = M_DSTART;
        M_DSTART: begin
          st.outSel   = O_TOKEN;
          st.blockClr = 1'b1;
          st.posClr   = 1'b1;
          modeNxt     = M_DREAD;
        end
        M_DREAD: begin
          st.outSel = O_RDATA;
          st.rdStep = 1'b1;
          if (rdLast || blkLast) begin
            st.posClr = 1'b1;
            modeNxt   = M_DCRC;
          end
        end
        M_DCRC: begin
          st.outSel   = O_CRC;
          st.crcShift = 1'b1;
          st.respAdv  = 1'b1;
          if (seqLast) begin
            st.posClr = 1'b1;
            modeNxt   = (blkFull && !singleRead) ? M_DGAP : M_CMD;
          end
        end
        M_DWRITE: begin
          st.outSel = O_ECHO;
          st.wrStep = 1'b1;
          if (wrFull || blkLast) begin
            st.posClr = 1'b1;
            modeNxt   = M_WSKIP;
          end
        end
        M_WSKIP: begin
          st.respAdv = 1'b1;
          if (seqLast) begin
            st.loadAccept = 1'b1;
            modeNxt       = M_RESP;
          end
        end
        default: modeNxt = M_CMD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= M_CMD;
    else       mode <= modeNxt;
  end

  p_start_token_r6: assert property (@(posedge clk) disable iff (!rstN)
    (slot && !abortRd && mode == M_DSTART) |=> (mode == M_DREAD));

  p_stop_return_r5: assert property (@(posedge clk) disable iff (!rstN)
    (slot && mode == M_RESP && respDone && stopping) |=> (mode == M_CMD && !stopping));

  p_abort_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (slot && readPhase && rxByte == STOP_LEAD) |=> (mode == M_ARG && stopping));

  p_cs_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!slot) |=> $stable(mode));

endmodule

// File: rtl/sdspi_dp.sv
module sdspi_dp
  import sdspi_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int RESP_MAX    = 5,
  parameter int ARG_BYTES   = 4,
  localparam int CNT_W = $clog2(BLOCK_BYTES + 1),
  localparam int LEN_W = $clog2(RESP_MAX + 1),
  localparam int ARG_W = 8 * ARG_BYTES,
  localparam int AC_W  = $clog2(ARG_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               st,
  input  logic [7:0]            rxByte,
  input  logic [LEN_W-1:0]      cmdRespLen,
  input  logic [8*RESP_MAX-1:0] cmdResp,
  input  logic [7:0]            rdByte,
  output logic [7:0]            txByte,
  output logic [5:0]            cmdIdxOut,
  output logic [ARG_W-1:0]      cmdArgOut,
  output logic                  argFull,
  output logic                  respDone,
  output logic                  stopping,
  output logic                  blkLast,
  output logic                  blkFull,
  output logic                  seqLast,
  output logic                  singleRead
);

  logic [5:0]            cmdIdx;
  logic [ARG_W-1:0]      cmdArg;
  logic [AC_W-1:0]       argCnt;
  logic [8*RESP_MAX-1:0] respBuf;
  logic [LEN_W-1:0]      respLen;
  logic [LEN_W-1:0]      respPos;
  logic [CNT_W-1:0]      blkCnt;
  logic [15:0]           crcReg;
  logic [7:0]            respSel;

  assign argFull    = (argCnt == AC_W'(ARG_BYTES));
  assign respDone   = (respPos >= respLen);
  assign blkLast    = (blkCnt == CNT_W'(BLOCK_BYTES - 1));
  assign blkFull    = (blkCnt == CNT_W'(BLOCK_BYTES));
  assign seqLast    = (respPos == LEN_W'(1));
  assign singleRead = (cmdIdx == IDX_RD_ONE);

  assign cmdIdxOut = st.issueStop ? IDX_STOP : cmdIdx;
  assign cmdArgOut = st.issueStop ? '0 : cmdArg;

  always_comb begin
    respSel = BYTE_IDLE;
    for (int i = 0; i < RESP_MAX; i++) begin
      if (respPos == LEN_W'(i)) respSel = respBuf[8*i +: 8];
    end
  end

  always_comb begin
    unique case (st.outSel)
      O_TOKEN: txByte = TOK_BLOCK;
      O_RESP:  txByte = respSel;
      O_RDATA: txByte = rdByte;
      O_CRC:   txByte = crcReg[15:8];
      O_ECHO:  txByte = rxByte;
      default: txByte = BYTE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdIdx   <= '0;
      cmdArg   <= '0;
      argCnt   <= '0;
      respBuf  <= '0;
      respLen  <= '0;
      respPos  <= '0;
      stopping <= 1'b0;
      blkCnt   <= '0;
      crcReg   <= '0;
    end else begin
      if (st.newCmd) begin
        cmdIdx <= rxByte[5:0];
        argCnt <= '0;
      end
      if (st.argShift) begin
        cmdArg <= {cmdArg[ARG_W-9:0], rxByte};
        argCnt <= argCnt + 1'b1;
      end
      if (st.issueCmd) begin
        respBuf <= cmdResp;
        respLen <= cmdRespLen;
        respPos <= '0;
      end
      if (st.issueStop) begin
        respBuf[7:0] <= (cmdRespLen == '0) ? 8'h00 : BYTE_IDLE;
        respLen      <= LEN_W'(1);
        respPos      <= '0;
      end
      if (st.respAdv) respPos <= respPos + 1'b1;
      if (st.posClr)  respPos <= '0;
      if (st.stopClr) begin
        stopping <= 1'b0;
      end else if (st.stopSet || st.issueStop || (st.issueCmd && isBusyCmd(cmdIdx))) begin
        stopping <= 1'b1;
      end
      if (st.blockClr) begin
        blkCnt <= '0;
        crcReg <= '0;
      end
      if (st.rdStep) begin
        blkCnt <= blkCnt + 1'b1;
        crcReg <= crcStep(crcReg, rdByte);
      end
      if (st.crcShift) crcReg <= {crcReg[7:0], 8'h00};
      if (st.wrStep)   blkCnt <= blkCnt + 1'b1;
      if (st.loadAccept) begin
        respBuf[7:0] <= WR_ACCEPTED;
        respLen      <= LEN_W'(1);
        respPos      <= '0;
        blkCnt       <= '0;
      end
    end
  end

  p_arg_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    argCnt <= AC_W'(ARG_BYTES));

  p_blk_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    blkCnt <= CNT_W'(BLOCK_BYTES));

  p_resp_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.issueCmd |=> (respLen <= LEN_W'(RESP_MAX) && respPos == '0));

endmodule

// File: rtl/sdspi_engine.sv
module sdspi_engine
  import sdspi_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int RESP_MAX    = 5,
  localparam int LEN_W = $clog2(RESP_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csN,
  input  logic                  xferEn,
  input  logic [7:0]            rxByte,
  output logic [7:0]            txByte,
  output logic                  cmdValid,
  output logic [5:0]            cmdIdx,
  output logic [31:0]           cmdArg,
  input  logic [LEN_W-1:0]      cmdRespLen,
  input  logic [8*RESP_MAX-1:0] cmdResp,
  input  logic                  rdAvail,
  input  logic                  rdLast,
  input  logic [7:0]            rdByte,
  output logic                  rdTake,
  output logic                  wrValid,
  output logic [7:0]            wrByte,
  input  logic                  wrFull
);

  strobe_t st;
  logic argFull, respDone, stopping, blkLast, blkFull, seqLast, singleRead;

  sdspi_ctrl #(.BLOCK_BYTES(BLOCK_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .xferEn(xferEn), .rxByte(rxByte),
    .argFull(argFull), .respDone(respDone), .stopping(stopping),
    .blkLast(blkLast), .blkFull(blkFull), .seqLast(seqLast),
    .singleRead(singleRead), .rdAvail(rdAvail), .rdLast(rdLast),
    .wrFull(wrFull), .st(st)
  );

  sdspi_dp #(.BLOCK_BYTES(BLOCK_BYTES), .RESP_MAX(RESP_MAX), .ARG_BYTES(4)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .rxByte(rxByte),
    .cmdRespLen(cmdRespLen), .cmdResp(cmdResp), .rdByte(rdByte),
    .txByte(txByte), .cmdIdxOut(cmdIdx), .cmdArgOut(cmdArg),
    .argFull(argFull), .respDone(respDone), .stopping(stopping),
    .blkLast(blkLast), .blkFull(blkFull), .seqLast(seqLast),
    .singleRead(singleRead)
  );

  assign cmdValid = st.issueCmd | st.issueStop;
  assign rdTake   = st.rdStep;
  assign wrValid  = st.wrStep;
  assign wrByte   = rxByte;

endmodule

// File: tb/tb_sdspi_engine.sv
module tb_sdspi_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        xferEn = 1'b0;
  logic [7:0]  rxByte = 8'hFF;
  logic [7:0]  txByte;
  logic        cmdValid;
  logic [5:0]  cmdIdx;
  logic [31:0] cmdArg;
  logic [2:0]  cmdRespLen;
  logic [39:0] cmdResp;
  logic        rdAvail, rdLast, rdTake, wrValid, wrFull;
  logic [7:0]  rdByte, wrByte;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sdspi_engine dut (
    .clk(clk), .rstN(rstN), .csN(csN), .xferEn(xferEn), .rxByte(rxByte),
    .txByte(txByte), .cmdValid(cmdValid), .cmdIdx(cmdIdx), .cmdArg(cmdArg),
    .cmdRespLen(cmdRespLen), .cmdResp(cmdResp), .rdAvail(rdAvail),
    .rdLast(rdLast), .rdByte(rdByte), .rdTake(rdTake), .wrValid(wrValid),
    .wrByte(wrByte), .wrFull(wrFull)
  );

  // back-end model state (committed) and the copy seen by the ports
  int rdRem = 0, rdPtr = 0, wrSpace = 0;
  int rdRemP = 0, rdPtrP = 0, wrSpaceP = 0;
  int cfgRd = 0, cfgWr = 0;
  bit stopBusy = 0;

  function automatic int beLen(input int idx);
    if (idx == 8 || idx == 58) return 5;
    if (idx == 12) return stopBusy ? 0 : 1;
    return 1;
  endfunction

  function automatic logic [7:0] beByte(input int idx, input int i);
    return 8'((idx * 3 + i * 17 + 1) & 255);
  endfunction

  function automatic logic [7:0] pattern(input int p);
    return 8'((p * 7 + 3) & 255);
  endfunction

  always_comb begin
    cmdRespLen = 3'(beLen(int'(cmdIdx)));
    for (int i = 0; i < 5; i++) cmdResp[8*i +: 8] = beByte(int'(cmdIdx), i);
  end
  assign rdAvail = (rdRemP > 0);
  assign rdLast  = (rdRemP == 1);
  assign rdByte  = pattern(rdPtrP);
  assign wrFull  = (wrSpaceP == 1);

  // protocol reference model
  int mm = 0, mIdx = 0, mArgN = 0, mPos = 0, mLen = 0, mCnt = 0;
  bit mStop = 0;
  logic [31:0] mArg = 0;
  logic [15:0] mCrc = 0;
  logic [7:0]  mResp[5];

  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      bit fb = r[15] ^ d[7-i];
      r = r << 1;
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic beIssue(input int idx);
    if (idx == 17) rdRem = 512;
    if (idx == 18) rdRem = cfgRd;
    if (idx == 12) rdRem = 0;
    if (idx == 38) rdRem = 3;
    if (idx == 24) wrSpace = 600;
    if (idx == 25) wrSpace = cfgWr;
  endtask

  function automatic string tagOf(input int m, input logic [7:0] v);
    if (m >= 4 && m <= 7 && v == 8'h4C) return "R9";
    case (m)
      0: return (v == 8'hFF) ? "R2" : (v == 8'hFE || v == 8'hFC) ? "R10" :
                (v == 8'hFD) ? "R11" : "R3";
      1: return "R3";
      2: return "R4";
      3: return mStop ? "R5" : "R4";
      4: return "R8";
      5, 6: return "R6";
      7: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input logic [7:0] v, output logic [7:0] o, output bit c,
                       output bit t, output bit w, output int ei, output logic [31:0] ea);
    o = 8'hFF; c = 0; t = 0; w = 0; ei = 0; ea = 0;
    if (mm >= 4 && mm <= 7 && v == 8'h4C) begin mm = 0; mStop = 1; end
    case (mm)
      0: begin
        if (v == 8'hFF) begin
        end else if (v == 8'hFE || v == 8'hFC) begin
          mm = 8; mCnt = 0;
        end else if (v == 8'hFD) begin
          c = 1; ei = 12; ea = 0;
          mResp[0] = (beLen(12) == 0) ? 8'h00 : 8'hFF;
          mLen = 1; mPos = 0; mStop = 1; mm = 3;
          beIssue(12);
        end else begin
          mIdx = int'(v & 8'h3F); mArgN = 0; mm = 1;
        end
      end
      1: begin
        if (mArgN == 4) begin
          c = 1; ei = mIdx; ea = mArg;
          mLen = beLen(mIdx);
          for (int i = 0; i < 5; i++) mResp[i] = beByte(mIdx, i);
          mPos = 0;
          if (mIdx == 28 || mIdx == 29 || mIdx == 38) mStop = 1;
          mm = 2;
          beIssue(mIdx);
        end else begin
          mArg = {mArg[23:0], v}; mArgN++;
        end
      end
      2: mm = 3;
      3: begin
        if (mPos < mLen) begin o = mResp[mPos]; mPos++; end
        else if (mStop) begin mStop = 0; mm = 0; end
        else if (rdRem > 0) mm = 5;
        else mm = 0;
      end
      4: mm = 5;
      5: begin o = 8'hFE; mCrc = 0; mCnt = 0; mPos = 0; mm = 6; end
      6: begin
        bit last;
        o = pattern(rdPtr); t = 1;
        mCrc = refCrc(mCrc, o); mCnt++;
        last = (rdRem == 1); rdRem--; rdPtr++;
        if (last || mCnt == 512) begin mm = 7; mPos = 0; end
      end
      7: begin
        o = mCrc[15:8]; mCrc = mCrc << 8; mPos++;
        if (mPos == 2) begin mm = (mCnt == 512 && mIdx != 17) ? 4 : 0; mPos = 0; end
      end
      8: begin
        bit full;
        o = v; w = 1; mCnt++;
        full = (wrSpace == 1); wrSpace--;
        if (full || mCnt == 512) begin mm = 9; mPos = 0; end
      end
      default: begin
        mPos++;
        if (mPos == 2) begin mm = 3; mResp[0] = 8'h05; mLen = 1; mPos = 0; mCnt = 0; end
      end
    endcase
  endtask

  task automatic fail(input string tag, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
  endtask

  task automatic xfer(input logic [7:0] v);
    logic [7:0] eo; bit ec, et, ew; int ei; logic [31:0] ea; string tag;
    @(negedge clk);
    csN = 1'b0; xferEn = 1'b1; rxByte = v;
    #1;
    tag = tagOf(mm, v);
    model(v, eo, ec, et, ew, ei, ea);
    checks++;
    if (txByte !== eo) fail(tag, "txByte", int'(txByte), int'(eo));
    else if (cmdValid !== ec) fail(tag, "cmdValid", int'(cmdValid), int'(ec));
    else if (ec && (int'(cmdIdx) != ei || cmdArg !== ea)) fail(tag, "cmdIdx/Arg", int'(cmdArg), int'(ea));
    else if (rdTake !== et) fail(tag, "rdTake", int'(rdTake), int'(et));
    else if (wrValid !== ew) fail(tag, "wrValid", int'(wrValid), int'(ew));
    else if (ew && wrByte !== v) fail(tag, "wrByte", int'(wrByte), int'(v));
    @(posedge clk); #1;
    xferEn = 1'b0;
    rdRemP = rdRem; rdPtrP = rdPtr; wrSpaceP = wrSpace;
  endtask

  // R12: a deselected strobe must reply 0xFF with no back-end action
  task automatic deselected(input logic [7:0] v);
    @(negedge clk);
    csN = 1'b1; xferEn = 1'b1; rxByte = v;
    #1;
    checks++;
    if (txByte !== 8'hFF || cmdValid || rdTake || wrValid)
      fail("R12", "deselected reply", int'(txByte), 8'hFF);
    @(posedge clk); #1;
    xferEn = 1'b0; csN = 1'b0;
  endtask

  task automatic pump(input int n);
    for (int i = 0; i < n; i++) xfer(8'hFF);
  endtask

  task automatic frame(input int idx, input logic [31:0] arg);
    xfer(8'h40 | 8'(idx));
    for (int i = 3; i >= 0; i--) xfer(arg[8*i +: 8]);
    xfer(8'h95);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;  // R1: reset state replies idle
    if (txByte !== 8'hFF || cmdValid || rdTake || wrValid) fail("R1", "reset outputs", int'(txByte), 8'hFF);
    @(negedge clk); rstN = 1'b1;
    pump(3);
    frame(0, 32'h0);            pump(4);
    frame(8, 32'h0000_01AA);    pump(8);
    // R12: deselected strobes in the middle of a frame
    xfer(8'h50); xfer(8'h12); xfer(8'h34);
    deselected(8'h4C); deselected(8'hFE); deselected(8'h00);
    xfer(8'h56); xfer(8'h78); xfer(8'h01); pump(4);
    frame(17, 32'h0000_0200);   pump(530);
    cfgRd = 600;
    frame(18, 32'h0000_0400);   pump(620);
    // R9: abort a long read during data
    cfgRd = 2000;
    frame(18, 32'h0);           pump(104);
    frame(12, 32'h0);           pump(6);
    // R9: abort during the CRC of the first block
    frame(18, 32'h0);           pump(2 + 1 + 1 + 512);
    frame(12, 32'h0);           pump(6);
    // R5: busy command ignores available data
    frame(38, 32'h0);           pump(5);
    frame(12, 32'h0);           pump(4);
    // R10: single-block write
    frame(24, 32'h0);           pump(3);
    xfer(8'hFE);
    for (int i = 0; i < 512; i++) xfer(8'(i ^ 8'h5A));
    xfer(8'hAB); xfer(8'hCD);   pump(4);
    // R10: multi-block write cut short by the back end
    cfgWr = 100;
    frame(25, 32'h0);           pump(3);
    xfer(8'hFC);
    for (int i = 0; i < 100; i++) xfer(8'(i * 5));
    xfer(8'h11); xfer(8'h22);   pump(3);
    // R11: stop token with busy and ready back end
    stopBusy = 1;
    xfer(8'hFD);                pump(3);
    stopBusy = 0;
    xfer(8'hFD);                pump(3);
    frame(58, 32'h0);           pump(8);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule